// File: doc/BRIEF.md
# ECC-Protected Parallel FIR Filter Bank

This block runs four independent sample streams through four identical FIR filters that share one set of tap coefficients. Three more FIR filters of the same shape act as checkers. Each checker filters a fixed three-way sum of the primary samples, so the parity groups follow a Hamming (7,4) pattern. The filters are linear and every sum is carried at full precision. In a fault-free cycle, each checker output therefore equals the sum of the primary outputs in its group. Any mismatch sets one bit of a three-bit syndrome.

The syndrome names the one filter among the seven that is faulty. If that filter is a primary, its output is rebuilt from a checker and the other members of a group that contains it. If it is a checker, the primary results are already good and pass through unchanged. In both cases an error flag and the index of the faulty filter are reported with the sample. A fault-injection port can XOR any mask onto the output of any one filter. The mask is captured together with the sample, so a testbench can prove that correction works against an ideal filter model.

The datapath is pipelined: the delay line feeds a registered multiplier stage, then a registered adder stage, and the corrected result is registered on the way out.

Top module: `ecc_fir_bank`

## Requirements
- R1: A sample taken with `vld_i` high at clock edge n appears with `vld_o` high right after edge n+3. `vld_o` is low in every cycle that does not carry such a sample.
- R2: Lane k output equals sum over t of h[t]*x_k[n-t], with h[t] = `coef_i[t*CW +: CW]` (signed) and x_k = `samp_i[k*DW +: DW]` (signed). The delay line advances only on samples taken with `vld_i` high, so idle cycles leave the history unchanged.
- R3: Lane outputs are two's-complement and OUTW = DW+CW+2+clog2(NTAP) bits wide. The output for lane k is `filt_o[k*OUTW +: OUTW]`. Extreme inputs (all samples and coefficients at the most negative value, or coefficients at the most positive value) produce the exact result with no wrap.
- R4: Checker filter p (p = 0, 1, 2) filters the sum of primary lanes {0,1,2}, {0,1,3} and {0,2,3} respectively. When no effective fault is injected, every syndrome bit is zero, `err_o` is low and `err_lane_o` is 0.
- R5: A fault on primary lane k (k = 0..3) gives the syndrome of the groups containing k: 111, 011, 101 or 110 (bit p = group p). The output of lane k is then replaced with the fault-free value, `err_o` goes high and `err_lane_o` = k.
- R6: A fault on checker p gives a syndrome with only bit p set. All four primary outputs stay fault-free, `err_o` goes high and `err_lane_o` = 4+p.
- R7: Injection indices 0..3 select the primary lanes and 4..6 select checkers 0..2. The mask is XORed onto that filter's output. The fields `inj_en_i`, `inj_lane_i` and `inj_mask_i` are captured with each valid sample and apply to that sample only. Index 7, a zero mask, or `inj_en_i` low has no effect on outputs or flags.
- R8: While `vld_o` is low, `filt_o` holds its last value and `err_o` and `err_lane_o` are 0.
- R9: While `rst_ni` is low, all outputs are 0. After release, the filter history starts from zero. Reset assertion is asynchronous; its release is synchronised over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Sample strobe for all four lanes |
| samp_i | input | 4*DW | Four signed samples, lane k at bits k*DW |
| coef_i | input | NTAP*CW | Signed taps, tap t at bits t*CW |
| inj_en_i | input | 1 | Fault injection enable, captured with the sample |
| inj_lane_i | input | 3 | Filter index to corrupt (0..6) |
| inj_mask_i | input | OUTW | XOR mask applied to that filter's output |
| vld_o | output | 1 | Corrected result valid |
| filt_o | output | 4*OUTW | Four corrected outputs, lane k at bits k*OUTW |
| err_o | output | 1 | A single faulty filter was found for this result |
| err_lane_o | output | 3 | Index of the faulty filter (0 when no error) |

## Verification
Every result, including its data, error flag and filter index, is due three clock edges after the edge that took the sample. The flags travel with the data, so none of them arrives a cycle early or late. The bench builds the ideal expectation when it drives a sample, queues it, and compares it at the falling edge that follows the third rising edge. Idle cycles are compared against the held outputs. Coefficients and fault settings are changed only after the pipeline has drained, or in the alternating burst they ride with each sample, so no expectation depends on a value that is already in flight.

// File: rtl/ecc_fir_pkg.sv
package ecc_fir_pkg;

  // Four data filters, three checker filters
  localparam int unsigned N_DATA = 4;
  localparam int unsigned N_PAR  = 3;
  localparam int unsigned N_LANE = N_DATA + N_PAR;
  localparam int unsigned LANE_W = $clog2(N_LANE + 1);

  // Membership of data lanes in each parity group: bit d of GRP[p]
  localparam logic [N_DATA-1:0] GRP [N_PAR] = '{4'b0111, 4'b1011, 4'b1101};

  typedef struct packed {
    logic              en;
    logic [LANE_W-1:0] lane;
  } inj_sel_t;

  // Syndrome produced by a fault on data lane d
  function automatic logic [N_PAR-1:0] col_of(input int unsigned d);
    logic [N_PAR-1:0] c;
    for (int p = 0; p < N_PAR; p++) c[p] = GRP[p][d];
    return c;
  endfunction

  // Lowest parity group that covers data lane d
  function automatic int unsigned home_of(input int unsigned d);
    int unsigned h;
    h = 0;
    for (int p = N_PAR - 1; p >= 0; p--) if (GRP[p][d]) h = p;
    return h;
  endfunction

endpackage

// File: rtl/ecc_fir_encode.sv
module ecc_fir_encode
  import ecc_fir_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = DW + 2
) (
  input  logic [N_DATA-1:0][DW-1:0] samp_i,
  output logic [N_PAR-1:0][IW-1:0]  sum_o
);

  logic signed [IW-1:0] acc;

  always_comb begin
    sum_o = '0;
    acc   = '0;
    for (int p = 0; p < N_PAR; p++) begin
      acc = '0;
      for (int d = 0; d < N_DATA; d++) begin
        if (GRP[p][d]) acc = acc + IW'($signed(samp_i[d]));
      end
      sum_o[p] = acc;
    end
  end

endmodule

// File: rtl/ecc_fir_lane.sv
module ecc_fir_lane #(
  parameter int unsigned IW   = 10,
  parameter int unsigned CW   = 8,
  parameter int unsigned NTAP = 4,
  parameter int unsigned OUTW = IW + CW + $clog2(NTAP)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      shift_en_i,
  input  logic                      mul_en_i,
  input  logic                      add_en_i,
  input  logic [IW-1:0]             x_i,
  input  logic [NTAP-1:0][CW-1:0]   coef_i,
  output logic [OUTW-1:0]           y_o
);

  localparam int unsigned PW = IW + CW;

  logic [NTAP-1:0][IW-1:0] tap_q, tap_d;
  logic [NTAP-1:0][PW-1:0] prod_q, prod_d;
  logic [OUTW-1:0]         acc_q, acc_d;
  logic signed [PW-1:0]    op_a, op_b;
  logic signed [OUTW-1:0]  sum;

  // Delay line: advances on valid samples only
  always_comb begin
    tap_d = tap_q;
    if (shift_en_i) begin
      tap_d[0] = x_i;
      for (int t = 1; t < NTAP; t++) tap_d[t] = tap_q[t-1];
    end
  end

  // Multiply stage
  always_comb begin
    prod_d = prod_q;
    op_a   = '0;
    op_b   = '0;
    if (mul_en_i) begin
      for (int t = 0; t < NTAP; t++) begin
        op_a      = PW'($signed(tap_q[t]));
        op_b      = PW'($signed(coef_i[t]));
        prod_d[t] = op_a * op_b;
      end
    end
  end

  // Add stage
  always_comb begin
    acc_d = acc_q;
    sum   = '0;
    if (add_en_i) begin
      for (int t = 0; t < NTAP; t++) sum = sum + OUTW'($signed(prod_q[t]));
      acc_d = sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q  <= '0;
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      tap_q  <= tap_d;
      prod_q <= prod_d;
      acc_q  <= acc_d;
    end
  end

  assign y_o = acc_q;

endmodule

// File: rtl/ecc_fir_correct.sv
module ecc_fir_correct
  import ecc_fir_pkg::*;
#(
  parameter int unsigned OUTW = 20
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic [N_LANE-1:0][OUTW-1:0]    obs_i,
  output logic [N_DATA-1:0][OUTW-1:0]    y_o,
  output logic                           err_o,
  output logic [LANE_W-1:0]              lane_o,
  output logic [N_PAR-1:0]               syn_o
);

  logic [N_PAR-1:0]              syn;
  logic [OUTW-1:0]               chk, rb;
  int unsigned                   grp;
  logic [N_DATA-1:0][OUTW-1:0]   fixd;
  logic [LANE_W-1:0]             loc;

  logic [N_DATA-1:0][OUTW-1:0]   y_q, y_d;
  logic                          err_q, err_d;
  logic [LANE_W-1:0]             lane_q, lane_d;

  // Syndrome: checker output minus the sum of its group
  always_comb begin
    syn = '0;
    chk = '0;
    for (int p = 0; p < N_PAR; p++) begin
      chk = obs_i[N_DATA+p];
      for (int d = 0; d < N_DATA; d++) begin
        if (GRP[p][d]) chk = chk - obs_i[d];
      end
      syn[p] = |chk;
    end
  end

  // Locate and rebuild
  always_comb begin
    fixd = obs_i[N_DATA-1:0];
    loc  = '0;
    rb   = '0;
    grp  = 0;
    for (int d = 0; d < N_DATA; d++) begin
      if (syn == col_of(d)) begin
        loc = LANE_W'(d);
        grp = home_of(d);
        rb  = obs_i[N_DATA+grp];
        for (int j = 0; j < N_DATA; j++) begin
          if (GRP[grp][j] && (j != d)) rb = rb - obs_i[j];
        end
        fixd[d] = rb;
      end
    end
    for (int p = 0; p < N_PAR; p++) begin
      if (syn == N_PAR'(1 << p)) loc = LANE_W'(N_DATA + p);
    end
  end

  always_comb begin
    y_d    = y_q;
    err_d  = 1'b0;
    lane_d = '0;
    if (en_i) begin
      y_d    = fixd;
      err_d  = |syn;
      lane_d = loc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q    <= '0;
      err_q  <= 1'b0;
      lane_q <= '0;
    end else begin
      y_q    <= y_d;
      err_q  <= err_d;
      lane_q <= lane_d;
    end
  end

  assign y_o    = y_q;
  assign err_o  = err_q;
  assign lane_o = lane_q;
  assign syn_o  = syn;

endmodule

// File: rtl/ecc_fir_bank.sv
module ecc_fir_bank
  import ecc_fir_pkg::*;
#(
  parameter  int unsigned DW   = 8,
  parameter  int unsigned CW   = 8,
  parameter  int unsigned NTAP = 4,
  localparam int unsigned OUTW = DW + CW + 2 + $clog2(NTAP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic [N_DATA*DW-1:0]     samp_i,
  input  logic [NTAP*CW-1:0]       coef_i,
  input  logic                     inj_en_i,
  input  logic [LANE_W-1:0]        inj_lane_i,
  input  logic [OUTW-1:0]          inj_mask_i,
  output logic                     vld_o,
  output logic [N_DATA*OUTW-1:0]   filt_o,
  output logic                     err_o,
  output logic [LANE_W-1:0]        err_lane_o
);

  localparam int unsigned IW = DW + 2;
  localparam int unsigned NS = 3;

  // Reset: asserted at once, released over two edges
  logic [1:0] rst_sync_q;
  logic       rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[1];

  // Stage valids: [0] taps, [1] products, [2] sums, [3] output
  logic [NS:0] st_q, st_d;
  assign st_d = {st_q[NS-1:0], vld_i};

  // Fault tag travels with its sample
  inj_sel_t [NS-1:0]           sel_q, sel_d;
  logic [NS-1:0][OUTW-1:0]     msk_q, msk_d;

  always_comb begin
    sel_d = sel_q;
    msk_d = msk_q;
    if (vld_i) begin
      sel_d[0] = {inj_en_i, inj_lane_i};
      msk_d[0] = inj_mask_i;
    end
    for (int s = 1; s < NS; s++) begin
      if (st_q[s-1]) begin
        sel_d[s] = sel_q[s-1];
        msk_d[s] = msk_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      st_q  <= '0;
      sel_q <= '0;
      msk_q <= '0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      msk_q <= msk_d;
    end
  end

  // Lane inputs
  logic [N_PAR-1:0][IW-1:0]    par_in;
  logic [N_LANE-1:0][IW-1:0]   lane_in;
  logic [N_LANE-1:0][OUTW-1:0] lane_raw, lane_obs;

  ecc_fir_encode #(.DW(DW), .IW(IW)) u_enc (
    .samp_i (samp_i),
    .sum_o  (par_in)
  );

  always_comb begin
    for (int d = 0; d < N_DATA; d++) lane_in[d] = IW'($signed(samp_i[d*DW +: DW]));
    for (int p = 0; p < N_PAR; p++) lane_in[N_DATA+p] = par_in[p];
  end

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    ecc_fir_lane #(.IW(IW), .CW(CW), .NTAP(NTAP), .OUTW(OUTW)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_n_q),
      .shift_en_i (vld_i),
      .mul_en_i   (st_q[0]),
      .add_en_i   (st_q[1]),
      .x_i        (lane_in[l]),
      .coef_i     (coef_i),
      .y_o        (lane_raw[l])
    );
  end

  // Fault injection on filter outputs
  always_comb begin
    for (int l = 0; l < N_LANE; l++) begin
      lane_obs[l] = lane_raw[l];
      if (sel_q[NS-1].en && (sel_q[NS-1].lane == LANE_W'(l)))
        lane_obs[l] = lane_raw[l] ^ msk_q[NS-1];
    end
  end

  logic             inj_live;
  logic [N_PAR-1:0] syn_w;
  assign inj_live = sel_q[NS-1].en && (int'(sel_q[NS-1].lane) < int'(N_LANE))
                    && (msk_q[NS-1] != '0);

  ecc_fir_correct #(.OUTW(OUTW)) u_fix (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .en_i   (st_q[NS-1]),
    .obs_i  (lane_obs),
    .y_o    (filt_o),
    .err_o  (err_o),
    .lane_o (err_lane_o),
    .syn_o  (syn_w)
  );

  assign vld_o = st_q[NS];

endmodule

// File: rtl/ecc_fir_bank_chk.sv
module ecc_fir_bank_chk
  import ecc_fir_pkg::*;
#(
  parameter int unsigned OUTW = 20
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   vld_i,
  input logic                   vld_o,
  input logic [N_DATA*OUTW-1:0] filt_o,
  input logic                   err_o,
  input logic [LANE_W-1:0]      err_lane_o,
  input logic                   stage_vld,
  input logic                   inj_live,
  input logic [LANE_W-1:0]      inj_lane,
  input logic [N_PAR-1:0]       syn
);

  logic [2:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 3'd7)   cyc_q <= cyc_q + 3'd1;
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd4) |-> (vld_o == $past(vld_i, 4)));

  assert_parity_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld && !inj_live) |-> (syn == '0));

  assert_flag_tracks_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_vld |=> (err_o == $past(inj_live)));

  assert_lane_reported_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld && inj_live) |=> (err_lane_o == $past(inj_lane)));

  assert_idle_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (!err_o && (err_lane_o == '0)));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(filt_o));

endmodule

bind ecc_fir_bank ecc_fir_bank_chk #(.OUTW(OUTW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n_q),
  .vld_i      (vld_i),
  .vld_o      (vld_o),
  .filt_o     (filt_o),
  .err_o      (err_o),
  .err_lane_o (err_lane_o),
  .stage_vld  (st_q[2]),
  .inj_live   (inj_live),
  .inj_lane   (sel_q[2].lane),
  .syn        (syn_w)
);

// File: tb/test_ecc_fir_bank.sv
`timescale 1ns/1ps
module test_ecc_fir_bank;
  localparam int DW   = 8;
  localparam int CW   = 8;
  localparam int NTAP = 4;
  localparam int NL   = 4;
  localparam int OUTW = DW + CW + 2 + $clog2(NTAP);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 vld = 1'b0;
  logic [NL*DW-1:0]     samp = '0;
  logic [NTAP*CW-1:0]   coef = '0;
  logic                 inj_en = 1'b0;
  logic [2:0]           inj_lane = '0;
  logic [OUTW-1:0]      inj_mask = '0;
  logic                 vld_o;
  logic [NL*OUTW-1:0]   filt_o;
  logic                 err_o;
  logic [2:0]           err_lane_o;

  always #2 clk = ~clk;

  ecc_fir_bank #(.DW(DW), .CW(CW), .NTAP(NTAP)) i_ecc_fir_bank (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .vld_i      (vld),
    .samp_i     (samp),
    .coef_i     (coef),
    .inj_en_i   (inj_en),
    .inj_lane_i (inj_lane),
    .inj_mask_i (inj_mask),
    .vld_o      (vld_o),
    .filt_o     (filt_o),
    .err_o      (err_o),
    .err_lane_o (err_lane_o)
  );

  typedef struct {
    bit     v;
    longint y [NL];
    bit     e;
    int     lane;
  } exp_t;

  exp_t   q [$];
  longint hist [NL][NTAP];
  longint last [NL];
  int     checks = 0;
  int     errors = 0;
  string  tag = "R9";

  function automatic longint samp_v(int k);
    logic signed [DW-1:0] s;
    s = samp[k*DW +: DW];
    return longint'(s);
  endfunction

  function automatic longint coef_v(int t);
    logic signed [CW-1:0] s;
    s = coef[t*CW +: CW];
    return longint'(s);
  endfunction

  function automatic longint out_v(int k);
    logic signed [OUTW-1:0] s;
    s = filt_o[k*OUTW +: OUTW];
    return longint'(s);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(exp_t e);
    check(vld_o == e.v, "R1", "vld_o", longint'(vld_o), longint'(e.v));
    if (e.v) begin
      for (int k = 0; k < NL; k++) begin
        check(out_v(k) == e.y[k], tag, $sformatf("lane %0d output", k), out_v(k), e.y[k]);
        last[k] = e.y[k];
      end
      check(err_o == e.e, tag, "err_o", longint'(err_o), longint'(e.e));
      check(int'(err_lane_o) == e.lane, tag, "err_lane_o", longint'(err_lane_o), longint'(e.lane));
    end else begin
      check(!err_o && err_lane_o == 0, "R8", "idle flags", longint'({err_o, err_lane_o}), 0);
      for (int k = 0; k < NL; k++)
        check(out_v(k) == last[k], "R8", $sformatf("lane %0d hold", k), out_v(k), last[k]);
    end
  endtask

  task automatic tick();
    exp_t e;
    e.v = vld;
    e.e = 1'b0;
    e.lane = 0;
    for (int k = 0; k < NL; k++) e.y[k] = 0;
    if (vld) begin
      for (int k = 0; k < NL; k++) begin
        for (int t = NTAP - 1; t > 0; t--) hist[k][t] = hist[k][t-1];
        hist[k][0] = samp_v(k);
        for (int t = 0; t < NTAP; t++) e.y[k] += coef_v(t) * hist[k][t];
      end
      if (inj_en && inj_lane < 3'd7 && inj_mask != '0) begin
        e.e = 1'b1;
        e.lane = int'(inj_lane);
      end
    end
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    if (q.size() == 4) compare(q.pop_front());
  endtask

  task automatic flush();
    vld = 1'b0;
    inj_en = 1'b0;
    repeat (5) tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vld = 1'b0;
    inj_en = 1'b0;
    q.delete();
    for (int k = 0; k < NL; k++) begin
      last[k] = 0;
      for (int t = 0; t < NTAP; t++) hist[k][t] = 0;
    end
    repeat (3) @(negedge clk);
    check(vld_o == 1'b0, "R9", "vld_o in reset", longint'(vld_o), 0);
    check(filt_o == '0, "R9", "filt_o in reset", longint'(filt_o[OUTW-1:0]), 0);
    check(!err_o && err_lane_o == 0, "R9", "flags in reset", longint'({err_o, err_lane_o}), 0);
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic burst(int n, bit rand_vld);
    for (int i = 0; i < n; i++) begin
      samp = $urandom;
      vld = rand_vld ? 1'($urandom_range(0, 1)) : 1'b1;
      tick();
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tag = "R9";
    do_reset();

    // R2: impulse per lane, taps 1..4
    tag = "R2";
    for (int t = 0; t < NTAP; t++) coef[t*CW +: CW] = CW'(t + 1);
    for (int k = 0; k < NL; k++) samp[k*DW +: DW] = DW'(k + 1);
    vld = 1'b1;
    tick();
    samp = '0;
    repeat (5) tick();
    flush();

    // R2: random samples with idle gaps
    burst(30, 1'b1);
    flush();

    // R4: random taps, dense stream, no fault
    tag = "R4";
    coef = $urandom;
    burst(40, 1'b0);
    flush();

    // R3: extreme values
    tag = "R3";
    coef = {NTAP{8'h80}};
    samp = {NL{8'h80}};
    vld = 1'b1;
    repeat (6) tick();
    flush();
    coef = {NTAP{8'h7f}};
    samp = {NL{8'h80}};
    vld = 1'b1;
    repeat (6) tick();
    flush();

    // R5: primary lane faults
    tag = "R5";
    coef = $urandom;
    for (int l = 0; l < 4; l++) begin
      inj_en = 1'b1;
      inj_lane = 3'(l);
      inj_mask = OUTW'($urandom) | OUTW'(1);
      burst(6, 1'b0);
      flush();
    end

    // R6: checker faults
    tag = "R6";
    for (int l = 4; l < 7; l++) begin
      inj_en = 1'b1;
      inj_lane = 3'(l);
      inj_mask = OUTW'($urandom) | OUTW'(1 << l);
      burst(6, 1'b0);
      flush();
    end

    // R7: injections with no effect, then per-sample capture
    tag = "R7";
    inj_en = 1'b1; inj_lane = 3'd7; inj_mask = OUTW'($urandom) | OUTW'(1);
    burst(6, 1'b0);
    flush();
    inj_en = 1'b1; inj_lane = 3'd2; inj_mask = '0;
    burst(6, 1'b0);
    flush();
    inj_en = 1'b0; inj_lane = 3'd1; inj_mask = OUTW'($urandom) | OUTW'(1);
    burst(6, 1'b0);
    flush();
    for (int i = 0; i < 14; i++) begin
      inj_en = 1'($urandom_range(0, 1));
      inj_lane = 3'($urandom_range(0, 6));
      inj_mask = OUTW'($urandom) | OUTW'(4);
      samp = $urandom;
      vld = 1'b1;
      tick();
    end
    flush();

    // R9: mid-run reset clears history
    tag = "R9";
    burst(5, 1'b0);
    do_reset();
    for (int k = 0; k < NL; k++) samp[k*DW +: DW] = DW'(3 * k + 2);
    vld = 1'b1;
    tick();
    samp = '0;
    repeat (4) tick();
    flush();

    summary();
    $finish;
  end

endmodule